// File: doc/BRIEF.md
# Zero-Overhead Hardware Loop Controller

This block sits beside a program sequencer and runs counted loops without branch instructions. A loop-setup command gives three things: the address of the setup instruction itself, the address of the loop's final instruction, and a pass count. The body begins at the address after the setup instruction. From then on, every valid fetch address is compared with the end address of the innermost active loop. On a match, the block either tells the sequencer to fetch the body start next, or it reports that the count has expired and lets fetch carry on to the following address. The decision is made in the same cycle as the fetch, so looping back costs no cycles.

Loops can be nested up to a parameterised depth, four by default, and they are held on a small stack. A loop leaves the stack in the cycle its final pass fetches the end address. Pushing onto a full stack is refused and raises a sticky error flag.

Top module: `zol_ctrl`

## Requirements
- R1: After reset the stack is empty: `redirect_vld`, `lce` and `stack_ovf` are all 0, and no fetch address causes a redirect.
- R2: A cycle with `setup_vld` high pushes a loop whose start is `setup_pc + 1`, whose end is `setup_end` and whose count is `setup_count`. That loop becomes the innermost one from the next cycle on.
- R3: When the fetch of the innermost loop's end address is valid and that loop's remaining count is greater than 1, `redirect_vld` is 1 and `redirect_pc` equals the loop start in the same cycle. The remaining count then drops by one.
- R4: When the fetch of the innermost loop's end address is valid and the remaining count is 1, `lce` is 1 and `redirect_vld` is 0 in that cycle. The loop is then removed from the stack, and `redirect_vld` and `lce` are never 1 together.
- R5: A loop loaded with a count of 0 runs one pass, exactly like a count of 1.
- R6: A fetch with `fetch_vld` low, or a fetch whose address differs from the innermost end address, leaves `redirect_vld` and `lce` at 0 and does not change the remaining count.
- R7: Only the innermost loop is compared. Once it expires, the enclosing loop resumes with its own remaining count.
- R8: A push while the stack already holds DEPTH loops is dropped and sets `stack_ovf`. The flag stays at 1 until reset, and the loops already held keep working.
- R9: If a push and a valid end-address fetch fall in the same cycle, the fetch acts on the loop that was innermost before the push. The pushed count belongs only to the new loop.
- R10: Counts use the full `CW`-bit width (16 by default). For example, a count of 300 gives 299 redirects followed by one `lce`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_vld | input | 1 | Fetch address is valid this cycle |
| fetch_pc | input | AW | Address being fetched |
| setup_vld | input | 1 | Loop-setup command present |
| setup_pc | input | AW | Address of the setup instruction |
| setup_end | input | AW | Address of the loop's last instruction |
| setup_count | input | CW | Pass count (0 treated as 1) |
| redirect_vld | output | 1 | Override next fetch with `redirect_pc` |
| redirect_pc | output | AW | Start address of the innermost loop |
| lce | output | 1 | Loop count expired at this end fetch |
| stack_ovf | output | 1 | Sticky: a push found the stack full |

## Verification
Loop setup and loop-end handling can fall in the same cycle. This happens when a new loop is pushed while the enclosing loop's end address is being fetched. The bench provokes this twice: once while the outer loop still has passes left, where a redirect is expected, and once on its final pass, where `lce` is expected and the new entry replaces the popped one. A scoreboard model that keeps its own stack then predicts the redirects and expiry of the following iterations. Those predictions show whether the new count went to the new loop and left the enclosing loop's count alone.

// File: rtl/zol_ctrl.sv
module zol_ctrl #(
  parameter int AW    = 16,
  parameter int CW    = 16,
  parameter int DEPTH = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fetch_vld,
  input  logic [AW-1:0] fetch_pc,
  input  logic          setup_vld,
  input  logic [AW-1:0] setup_pc,
  input  logic [AW-1:0] setup_end,
  input  logic [CW-1:0] setup_count,
  output logic          redirect_vld,
  output logic [AW-1:0] redirect_pc,
  output logic          lce,
  output logic          stack_ovf
);

  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int DW = $clog2(DEPTH + 1);

  logic [AW-1:0] st_start [DEPTH];
  logic [AW-1:0] st_end   [DEPTH];
  logic [CW-1:0] st_cnt   [DEPTH];
  logic [DW-1:0] depth;
  logic          ovf_q;

  logic [IW-1:0] top;
  logic [IW-1:0] wr;
  logic [DW-1:0] d_after;
  logic          hit, last, full;
  logic [CW-1:0] load_cnt;

  assign top      = IW'(depth - DW'(1));
  assign hit      = fetch_vld && (depth != '0) && (fetch_pc == st_end[top]);
  assign last     = (st_cnt[top] == CW'(1));
  assign redirect_vld = hit && !last;
  assign redirect_pc  = st_start[top];
  assign lce          = hit && last;
  assign stack_ovf    = ovf_q;

  assign d_after  = depth - DW'(lce);
  assign full     = (d_after == DW'(DEPTH));
  assign wr       = IW'(d_after);
  assign load_cnt = (setup_count == '0) ? CW'(1) : setup_count;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      depth <= '0;
      ovf_q <= 1'b0;
      for (int i = 0; i < DEPTH; i++) begin
        st_start[i] <= '0;
        st_end[i]   <= '0;
        st_cnt[i]   <= '0;
      end
    end else begin
      if (redirect_vld) st_cnt[top] <= st_cnt[top] - CW'(1);
      if (setup_vld && full) ovf_q <= 1'b1;
      if (setup_vld && !full) begin
        st_start[wr] <= setup_pc + AW'(1);
        st_end[wr]   <= setup_end;
        st_cnt[wr]   <= load_cnt;
      end
      depth <= d_after + DW'(setup_vld && !full);
    end
  end

  assert_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(redirect_vld && lce));

  assert_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !fetch_vld |-> (!redirect_vld && !lce));

  assert_pop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (lce && !setup_vld) |=> (depth == $past(depth) - DW'(1)));

  assert_push_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (setup_vld && !lce && depth < DW'(DEPTH)) |=> (depth == $past(depth) + DW'(1)));

  assert_ovf_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    stack_ovf |=> stack_ovf);

  assert_full_push_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (setup_vld && !lce && depth == DW'(DEPTH)) |=> (stack_ovf && depth == DW'(DEPTH)));

  assert_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    depth <= DW'(DEPTH));

endmodule

// File: tb/tb_zol_ctrl.sv
module tb_zol_ctrl;
  localparam int AW = 16;
  localparam int CW = 16;
  localparam int DEPTH = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fetch_vld = 1'b0;
  logic [AW-1:0] fetch_pc = '0;
  logic setup_vld = 1'b0;
  logic [AW-1:0] setup_pc = '0;
  logic [AW-1:0] setup_end = '0;
  logic [CW-1:0] setup_count = '0;
  logic redirect_vld, lce, stack_ovf;
  logic [AW-1:0] redirect_pc;

  always #2.5 clk = ~clk;

  zol_ctrl #(.AW(AW), .CW(CW), .DEPTH(DEPTH)) dut (
    .clk(clk), .rst_n(rst_n), .fetch_vld(fetch_vld), .fetch_pc(fetch_pc),
    .setup_vld(setup_vld), .setup_pc(setup_pc), .setup_end(setup_end),
    .setup_count(setup_count), .redirect_vld(redirect_vld),
    .redirect_pc(redirect_pc), .lce(lce), .stack_ovf(stack_ovf));

  typedef struct {
    logic          red;
    logic [AW-1:0] pc;
    logic          lce;
    logic          ovf;
    string         tag;
  } exp_t;

  exp_t q[$];
  int checks = 0;
  int errors = 0;

  int m_start [DEPTH];
  int m_end   [DEPTH];
  int m_cnt   [DEPTH];
  int m_depth = 0;
  bit m_ovf   = 0;

  task automatic step(input bit fv, input int pc, input bit sv,
                      input int dopc, input int endpc, input int cnt,
                      input string tag);
    exp_t e;
    @(negedge clk);
    fetch_vld = fv; fetch_pc = AW'(pc);
    setup_vld = sv; setup_pc = AW'(dopc); setup_end = AW'(endpc);
    setup_count = CW'(cnt);
    e.red = 0; e.pc = '0; e.lce = 0; e.ovf = m_ovf; e.tag = tag;
    if (fv && m_depth > 0 && pc == m_end[m_depth-1]) begin
      if (m_cnt[m_depth-1] <= 1) begin
        e.lce = 1; m_depth--;
      end else begin
        e.red = 1; e.pc = AW'(m_start[m_depth-1]); m_cnt[m_depth-1]--;
      end
    end
    if (sv) begin
      if (m_depth == DEPTH) m_ovf = 1;
      else begin
        m_start[m_depth] = dopc + 1; m_end[m_depth] = endpc;
        m_cnt[m_depth] = (cnt == 0) ? 1 : cnt; m_depth++;
      end
    end
    q.push_back(e);
  endtask

  task automatic fetch(input int pc, input string tag);
    step(1, pc, 0, 0, 0, 0, tag);
  endtask

  task automatic setup(input int dopc, input int endpc, input int cnt, input string tag);
    step(0, 0, 1, dopc, endpc, cnt, tag);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; fetch_vld = 0; setup_vld = 0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1;
    m_depth = 0; m_ovf = 0;
  endtask

  task automatic drain();
    @(negedge clk);
    fetch_vld = 0; setup_vld = 0;
    while (q.size() != 0) @(negedge clk);
  endtask

  initial begin : monitor
    exp_t e;
    forever begin
      @(negedge clk);
      #2;
      if (q.size() != 0) begin
        e = q.pop_front();
        checks++;
        if (redirect_vld !== e.red || lce !== e.lce || stack_ovf !== e.ovf ||
            (e.red && redirect_pc !== e.pc)) begin
          errors++;
          $display("FAIL %s: got red=%0b pc=%0d lce=%0b ovf=%0b, expected red=%0b pc=%0d lce=%0b ovf=%0b",
                   e.tag, redirect_vld, redirect_pc, lce, stack_ovf, e.red, e.pc, e.lce, e.ovf);
        end
      end
    end
  end

  initial begin : watchdog
    #1000000;
    errors++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    do_reset();
    // R1: reset state, fetching any address does nothing
    #2;
    checks++;
    if (redirect_vld !== 0 || lce !== 0 || stack_ovf !== 0) begin
      errors++;
      $display("FAIL R1: got red=%0b lce=%0b ovf=%0b, expected 0 0 0", redirect_vld, lce, stack_ovf);
    end
    fetch(0, "R1");
    fetch(5, "R1");

    // R2 R3 R4: three passes of a three-instruction body
    setup(10, 13, 3, "R2");
    for (int p = 0; p < 3; p++) begin
      fetch(11, "R6"); fetch(12, "R6");
      fetch(13, (p < 2) ? "R3" : "R4");
    end
    fetch(14, "R4");
    fetch(13, "R4");

    // R5: count 0 and count 1 give one pass
    setup(20, 21, 0, "R5");
    fetch(21, "R5");
    fetch(21, "R5");
    setup(20, 21, 1, "R5");
    fetch(21, "R5");

    // R6: invalid fetch of end address, other addresses
    setup(30, 32, 2, "R6");
    step(0, 32, 0, 0, 0, 0, "R6");
    fetch(31, "R6");
    fetch(33, "R6");
    fetch(32, "R6");
    fetch(32, "R6");

    // R7: nesting
    setup(40, 50, 2, "R7");
    for (int o = 0; o < 2; o++) begin
      fetch(41, "R7");
      setup(41, 44, 2, "R7");
      for (int i = 0; i < 2; i++) begin fetch(43, "R7"); fetch(44, "R7"); end
      fetch(45, "R7");
      fetch(50, "R7");
    end
    fetch(51, "R7");

    // R9: push in same cycle as outer end fetch (outer has passes left)
    setup(60, 70, 3, "R9");
    step(1, 70, 1, 70, 72, 2, "R9");
    fetch(72, "R9");
    fetch(72, "R9");
    fetch(70, "R9");
    fetch(70, "R9");
    // R9: push in same cycle as final end fetch
    setup(80, 82, 1, "R9");
    step(1, 82, 1, 82, 84, 3, "R9");
    fetch(84, "R9"); fetch(84, "R9"); fetch(84, "R9"); fetch(84, "R9");
    drain();

    // R10: wide count
    do_reset();
    setup(99, 100, 300, "R10");
    for (int k = 0; k < 300; k++) fetch(100, "R10");
    fetch(100, "R10");
    drain();

    // R8: overflow on fifth push
    do_reset();
    setup(200, 210, 2, "R8");
    setup(201, 209, 2, "R8");
    setup(202, 208, 2, "R8");
    setup(203, 207, 2, "R8");
    setup(204, 206, 5, "R8");
    fetch(206, "R8");
    fetch(207, "R8");
    fetch(207, "R8");
    fetch(208, "R8");
    fetch(208, "R8");
    fetch(209, "R8");
    fetch(209, "R8");
    fetch(210, "R8");
    fetch(210, "R8");
    fetch(210, "R8");
    drain();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule